// File: doc/BRIEF.md
# Receive Frame Gate

This block sits between a UART receiver and its receive FIFO. Each received frame arrives as a single-cycle strobe carrying up to nine data bits, a parity-error bit and a framing-error bit. The gate decides whether the frame is written to the FIFO, and in the same cycle it reports three events: a start-frame match, a signal-frame match and a multiprocessor address frame.

The receiver can be shut with command pulses, so that ordinary traffic is discarded. Two kinds of frame still get through a shut gate. The first is an address frame in multiprocessor mode. The second is a frame equal to the programmed start value, when start unblocking is enabled; that frame reopens the gate and is stored. A separate option discards any frame that has a parity error.

The gate state is held by a two-state machine. `GATE_OPEN` passes frames. `GATE_SHUT` discards them, except for the two cases above. The transitions are:
- **shut**: `GATE_OPEN` to `GATE_SHUT`, on a set pulse without a clear pulse.
- **release**: `GATE_SHUT` to `GATE_OPEN`, on a clear pulse.
- **wake**: `GATE_SHUT` to `GATE_OPEN`, on an unblocking start-frame match.

All outputs are registered and appear one clock after the frame strobe.

Top module: `rx_frame_gate`

## Requirements
- R1: After reset, `wr_en`, `wr_data`, `wr_perr`, `wr_ferr`, all three event outputs and `blocked` are 0. The gate starts in `GATE_OPEN`.
- R2: While the gate is open, every frame strobe produces a one-cycle `wr_en` in the next cycle. That cycle carries the frame data masked to the configured length, plus its parity-error and framing-error bits. Length code 1 selects 7 bits, code 3 selects 9 bits, and codes 0 and 2 select 8 bits. Data bits above the length read as 0.
- R3: A `blk_set` pulse shuts the gate and a `blk_clr` pulse opens it. When both arrive in the same cycle, the gate ends open. `blocked` shows the state one cycle after the pulse.
- R4: While the gate is shut, an ordinary frame is not written, and the gate stays shut.
- R5: A frame is an address frame when `mp_en` is 1, the length code is 3, and frame bit 8 equals `mp_addr_bit`. An address frame raises `ev_addr` and is written even while the gate is shut; the gate stays shut. With `mp_en` at 0, bit 8 is plain data.
- R6: A frame whose masked value equals the masked `start_ref` raises `ev_start`. If `sf_unblock_en` is 1 and the gate is shut, the gate reopens and that same frame is written. If `sf_unblock_en` is 0, a shut gate stays shut and the frame is dropped.
- R7: A frame whose masked value equals the masked `sig_ref` raises `ev_sig`. This match has no effect on storage or on the gate state.
- R8: With `skip_perr` at 1, a frame with a parity error is never written. Its events are still raised. With `skip_perr` at 0, such a frame is written with `wr_perr` set to 1.
- R9: Comparisons use only the configured data length. For example, with 7-bit frames, a `start_ref` of 0x1A5 matches frames 0x025 and 0x0A5. With 9-bit frames, the same `start_ref` does not match 0x025.
- R10: A cycle with no frame strobe produces no write and no event in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | One-cycle strobe for a received frame |
| frm_data | input | 9 | Received frame data bits |
| frm_perr | input | 1 | Parity error of the frame |
| frm_ferr | input | 1 | Framing error of the frame |
| len_code | input | 2 | Data length: 1 = 7 bits, 3 = 9 bits, 0 or 2 = 8 bits |
| start_ref | input | 9 | Start-frame comparison value |
| sig_ref | input | 9 | Signal-frame comparison value |
| mp_en | input | 1 | Multiprocessor mode |
| mp_addr_bit | input | 1 | Bit 8 value that marks an address frame |
| sf_unblock_en | input | 1 | A start-frame match reopens a shut gate |
| skip_perr | input | 1 | Discard frames with a parity error |
| blk_set | input | 1 | Pulse that shuts the gate |
| blk_clr | input | 1 | Pulse that opens the gate; wins over `blk_set` |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 9 | Masked frame data to store |
| wr_perr | output | 1 | Stored parity-error bit |
| wr_ferr | output | 1 | Stored framing-error bit |
| ev_start | output | 1 | Start-frame match pulse |
| ev_sig | output | 1 | Signal-frame match pulse |
| ev_addr | output | 1 | Address-frame pulse |
| blocked | output | 1 | Gate is shut |

## Verification
Frames are sent with the gate open and with it shut. This separates plain storage from the three bypass paths: address frames, start frames with unblocking on, and start frames with unblocking off.

The same 9-bit pattern 0x123 is sent with multiprocessor mode on and off. This shows whether bit 8 is treated as data or as an address mark.

Start and signal matches are tried at 7-bit and 9-bit lengths, using values that differ only in the masked bits, to expose comparisons made on the wrong width. Parity-error frames are sent with the skip option set and cleared, including a start frame with a parity error. This confirms that dropping a frame does not suppress its events.

// File: rtl/rfg_pkg.sv
package rfg_pkg;

    localparam int FRAME_W = 9;
    localparam int LEN_W   = 2;

    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic {
        GATE_OPEN = 1'b0,
        GATE_SHUT = 1'b1
    } gate_state_t;

    typedef struct packed {
        frame_t data;
        logic   perr;
        logic   ferr;
    } rx_entry_t;

    // Length code: 1 -> FRAME_W-2 bits, 3 -> FRAME_W bits, else FRAME_W-1 bits
    function automatic frame_t len_mask(input logic [LEN_W-1:0] code);
        frame_t m;
        unique case (code)
            2'd1:    m = frame_t'((1 << (FRAME_W-2)) - 1);
            2'd3:    m = '1;
            default: m = frame_t'((1 << (FRAME_W-1)) - 1);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rfg_match.sv
module rfg_match #(
    parameter int W     = 9,
    parameter int N_REF = 2
) (
    input  logic [W-1:0]       frame,
    input  logic [W-1:0]       refs [N_REF],
    output logic [N_REF-1:0]   hit
);
    for (genvar i = 0; i < N_REF; i++) begin : g_cmp
        assign hit[i] = (frame == refs[i]);
    end
endmodule

// File: rtl/rfg_classify.sv
module rfg_classify
    import rfg_pkg::*;
(
    input  logic                 frm_valid,
    input  frame_t               frm_data,
    input  logic                 frm_perr,
    input  logic [LEN_W-1:0]     len_code,
    input  frame_t               start_ref,
    input  frame_t               sig_ref,
    input  logic                 mp_en,
    input  logic                 mp_addr_bit,
    input  logic                 sf_unblock_en,
    input  logic                 skip_perr,
    input  logic                 is_shut,
    output frame_t               masked,
    output logic                 keep,
    output logic                 start_hit,
    output logic                 sig_hit,
    output logic                 addr_hit,
    output logic                 wake
);
    localparam int N_REF   = 2;
    localparam int IDX_SF  = 0;
    localparam int IDX_SIG = 1;

    frame_t             mask;
    frame_t             refs_m [N_REF];
    logic [N_REF-1:0]   hits;

    always_comb begin
        mask            = len_mask(len_code);
        masked          = frm_data & mask;
        refs_m[IDX_SF]  = start_ref & mask;
        refs_m[IDX_SIG] = sig_ref & mask;
    end

    rfg_match #(.W(FRAME_W), .N_REF(N_REF)) u_match (
        .frame (masked),
        .refs  (refs_m),
        .hit   (hits)
    );

    always_comb begin
        start_hit = frm_valid && hits[IDX_SF];
        sig_hit   = frm_valid && hits[IDX_SIG];
        addr_hit  = frm_valid && mp_en && (len_code == 2'd3)
                    && (frm_data[FRAME_W-1] == mp_addr_bit);
        wake      = start_hit && sf_unblock_en;
        keep      = frm_valid && !(skip_perr && frm_perr)
                    && (!is_shut || addr_hit || wake);
    end
endmodule

// File: rtl/rfg_gate_fsm.sv
module rfg_gate_fsm
    import rfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blk_set,
    input  logic blk_clr,
    input  logic wake,
    output logic is_shut
);
    gate_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GATE_OPEN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            GATE_OPEN: if (blk_set && !blk_clr) state_nxt = GATE_SHUT;     // shut
            GATE_SHUT: if (blk_clr || wake)     state_nxt = GATE_OPEN;     // release / wake
            default:                            state_nxt = GATE_OPEN;
        endcase
    end

    always_comb begin
        is_shut = (state == GATE_SHUT);
    end
endmodule

// File: rtl/rfg_out_reg.sv
module rfg_out_reg
    import rfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       keep,
    input  rx_entry_t  entry_in,
    input  logic       start_hit,
    input  logic       sig_hit,
    input  logic       addr_hit,
    output logic       wr_en,
    output rx_entry_t  entry_out,
    output logic       ev_start,
    output logic       ev_sig,
    output logic       ev_addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            entry_out <= '0;
            ev_start  <= 1'b0;
            ev_sig    <= 1'b0;
            ev_addr   <= 1'b0;
        end else begin
            wr_en    <= keep;
            ev_start <= start_hit;
            ev_sig   <= sig_hit;
            ev_addr  <= addr_hit;
            if (keep) entry_out <= entry_in;
            else      entry_out <= '0;
        end
    end
endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate
    import rfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid,
    input  logic [FRAME_W-1:0]  frm_data,
    input  logic                frm_perr,
    input  logic                frm_ferr,
    input  logic [LEN_W-1:0]    len_code,
    input  logic [FRAME_W-1:0]  start_ref,
    input  logic [FRAME_W-1:0]  sig_ref,
    input  logic                mp_en,
    input  logic                mp_addr_bit,
    input  logic                sf_unblock_en,
    input  logic                skip_perr,
    input  logic                blk_set,
    input  logic                blk_clr,
    output logic                wr_en,
    output logic [FRAME_W-1:0]  wr_data,
    output logic                wr_perr,
    output logic                wr_ferr,
    output logic                ev_start,
    output logic                ev_sig,
    output logic                ev_addr,
    output logic                blocked
);
    frame_t    masked;
    logic      keep, start_hit, sig_hit, addr_hit, wake, is_shut;
    rx_entry_t entry_in, entry_out;

    rfg_classify u_cls (
        .frm_valid     (frm_valid),
        .frm_data      (frm_data),
        .frm_perr      (frm_perr),
        .len_code      (len_code),
        .start_ref     (start_ref),
        .sig_ref       (sig_ref),
        .mp_en         (mp_en),
        .mp_addr_bit   (mp_addr_bit),
        .sf_unblock_en (sf_unblock_en),
        .skip_perr     (skip_perr),
        .is_shut       (is_shut),
        .masked        (masked),
        .keep          (keep),
        .start_hit     (start_hit),
        .sig_hit       (sig_hit),
        .addr_hit      (addr_hit),
        .wake          (wake)
    );

    rfg_gate_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .blk_set (blk_set),
        .blk_clr (blk_clr),
        .wake    (wake),
        .is_shut (is_shut)
    );

    always_comb begin
        entry_in.data = masked;
        entry_in.perr = frm_perr;
        entry_in.ferr = frm_ferr;
    end

    rfg_out_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .keep      (keep),
        .entry_in  (entry_in),
        .start_hit (start_hit),
        .sig_hit   (sig_hit),
        .addr_hit  (addr_hit),
        .wr_en     (wr_en),
        .entry_out (entry_out),
        .ev_start  (ev_start),
        .ev_sig    (ev_sig),
        .ev_addr   (ev_addr)
    );

    always_comb begin
        wr_data = entry_out.data;
        wr_perr = entry_out.perr;
        wr_ferr = entry_out.ferr;
        blocked = is_shut;
    end
endmodule

// File: rtl/rfg_checker.sv
module rfg_checker (
    input logic clk,
    input logic rst_n,
    input logic frm_valid,
    input logic frm_perr,
    input logic frm_ferr,
    input logic mp_en,
    input logic sf_unblock_en,
    input logic skip_perr,
    input logic blk_set,
    input logic blk_clr,
    input logic wr_en,
    input logic wr_perr,
    input logic wr_ferr,
    input logic ev_start,
    input logic ev_sig,
    input logic ev_addr,
    input logic blocked
);
    // R10
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !wr_en && !ev_start && !ev_sig && !ev_addr);

    // R3
    p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_clr |=> !blocked);

    // R3
    p_set_shuts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_set && !blk_clr && !frm_valid |=> blocked);

    // R8
    p_skip_perr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && frm_perr && skip_perr |=> !wr_en);

    // R2
    p_open_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !blocked && !(frm_perr && skip_perr)
        |=> wr_en && (wr_perr == $past(frm_perr)) && (wr_ferr == $past(frm_ferr)));

    // R4
    p_shut_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && blocked && !mp_en && !sf_unblock_en |=> !wr_en);

    // R5
    p_addr_stored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr && !$past(frm_perr && skip_perr) |-> wr_en);

    // R6
    p_wake_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start && $past(sf_unblock_en) && !$past(blk_set) |-> !blocked);
endmodule

bind rx_frame_gate rfg_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frm_valid     (frm_valid),
    .frm_perr      (frm_perr),
    .frm_ferr      (frm_ferr),
    .mp_en         (mp_en),
    .sf_unblock_en (sf_unblock_en),
    .skip_perr     (skip_perr),
    .blk_set       (blk_set),
    .blk_clr       (blk_clr),
    .wr_en         (wr_en),
    .wr_perr       (wr_perr),
    .wr_ferr       (wr_ferr),
    .ev_start      (ev_start),
    .ev_sig        (ev_sig),
    .ev_addr       (ev_addr),
    .blocked       (blocked)
);

// File: tb/sim_rx_frame_gate.sv
module sim_rx_frame_gate;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_valid = 1'b0;
    logic [8:0] frm_data = '0;
    logic       frm_perr = 1'b0, frm_ferr = 1'b0;
    logic [1:0] len_code = 2'd3;
    logic [8:0] start_ref = 9'h1F0, sig_ref = 9'h0AA;
    logic       mp_en = 1'b0, mp_addr_bit = 1'b1;
    logic       sf_unblock_en = 1'b0, skip_perr = 1'b0;
    logic       blk_set = 1'b0, blk_clr = 1'b0;
    logic       wr_en, wr_perr, wr_ferr, ev_start, ev_sig, ev_addr, blocked;
    logic [8:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_gate u0 (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
        .frm_perr(frm_perr), .frm_ferr(frm_ferr), .len_code(len_code),
        .start_ref(start_ref), .sig_ref(sig_ref), .mp_en(mp_en),
        .mp_addr_bit(mp_addr_bit), .sf_unblock_en(sf_unblock_en),
        .skip_perr(skip_perr), .blk_set(blk_set), .blk_clr(blk_clr),
        .wr_en(wr_en), .wr_data(wr_data), .wr_perr(wr_perr), .wr_ferr(wr_ferr),
        .ev_start(ev_start), .ev_sig(ev_sig), .ev_addr(ev_addr), .blocked(blocked)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Frame is held for one cycle; outputs are sampled at the next falling edge.
    task automatic send(input logic [8:0] d, input logic pe, input logic fe);
        @(negedge clk);
        frm_valid = 1'b1; frm_data = d; frm_perr = pe; frm_ferr = fe;
        @(negedge clk);
        frm_valid = 1'b0; frm_data = '0; frm_perr = 1'b0; frm_ferr = 1'b0;
    endtask

    task automatic pulse(input logic s, input logic c);
        @(negedge clk);
        blk_set = s; blk_clr = c;
        @(negedge clk);
        blk_set = 1'b0; blk_clr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 wr_en", wr_en, 0);
        chk("R1 data", {wr_data, wr_perr, wr_ferr}, 0);
        chk("R1 events", {ev_start, ev_sig, ev_addr}, 0);
        chk("R1 blocked", blocked, 0);
    endtask

    task automatic t_open_store;
        send(9'h155, 0, 0);
        chk("R2 wr_en", wr_en, 1);
        chk("R2 data 9b", wr_data, 9'h155);
        send(9'h0F3, 0, 1);
        chk("R2 ferr", {wr_en, wr_ferr, wr_perr}, 3'b110);
        len_code = 2'd2;
        send(9'h1C3, 0, 0);
        chk("R2 data 8b", wr_data, 9'h0C3);
        len_code = 2'd0;
        send(9'h1C3, 0, 0);
        chk("R2 data code0", wr_data, 9'h0C3);
        len_code = 2'd1;
        send(9'h1C3, 0, 0);
        chk("R2 data 7b", wr_data, 9'h043);
        len_code = 2'd3;
        @(negedge clk);
        chk("R10 no write idle", {wr_en, ev_start, ev_sig, ev_addr}, 0);
    endtask

    task automatic t_block_cmd;
        pulse(1, 0);
        chk("R3 set shuts", blocked, 1);
        pulse(1, 1);
        chk("R3 clear wins", blocked, 0);
        pulse(1, 0);
        pulse(0, 1);
        chk("R3 clear opens", blocked, 0);
    endtask

    task automatic t_shut_drop;
        pulse(1, 0);
        send(9'h055, 0, 0);
        chk("R4 dropped", wr_en, 0);
        chk("R4 stays shut", blocked, 1);
        pulse(0, 1);
    endtask

    task automatic t_mp;
        mp_en = 1'b1; mp_addr_bit = 1'b1;
        pulse(1, 0);
        send(9'h123, 0, 0);
        chk("R5 addr stored", {wr_en, ev_addr}, 2'b11);
        chk("R5 addr data", wr_data, 9'h123);
        chk("R5 stays shut", blocked, 1);
        send(9'h023, 0, 0);
        chk("R5 non-addr dropped", {wr_en, ev_addr}, 2'b00);
        mp_en = 1'b0;
        send(9'h123, 0, 0);
        chk("R5 mp off plain", {wr_en, ev_addr}, 2'b00);
        pulse(0, 1);
        send(9'h123, 0, 0);
        chk("R5 mp off open", {wr_en, ev_addr}, 2'b10);
    endtask

    task automatic t_start;
        pulse(1, 0);
        sf_unblock_en = 1'b0;
        send(9'h1F0, 0, 0);
        chk("R6 event no unblock", {ev_start, wr_en, blocked}, 3'b101);
        sf_unblock_en = 1'b1;
        send(9'h1F0, 0, 0);
        chk("R6 wake stores", {ev_start, wr_en, blocked}, 3'b110);
        chk("R6 wake data", wr_data, 9'h1F0);
        send(9'h011, 0, 0);
        chk("R6 open after wake", {wr_en, ev_start}, 2'b10);
        sf_unblock_en = 1'b0;
    endtask

    task automatic t_sig;
        pulse(1, 0);
        send(9'h0AA, 0, 0);
        chk("R7 sig shut", {ev_sig, wr_en, blocked}, 3'b101);
        pulse(0, 1);
        send(9'h0AA, 0, 0);
        chk("R7 sig open", {ev_sig, wr_en, blocked}, 3'b110);
    endtask

    task automatic t_perr;
        send(9'h031, 1, 0);
        chk("R8 no skip stores", {wr_en, wr_perr}, 2'b11);
        skip_perr = 1'b1;
        send(9'h031, 1, 0);
        chk("R8 skip drops", wr_en, 0);
        send(9'h1F0, 1, 0);
        chk("R8 event kept", {ev_start, wr_en}, 2'b10);
        send(9'h032, 0, 0);
        chk("R8 clean stored", {wr_en, wr_data}, {1'b1, 9'h032});
        skip_perr = 1'b0;
    endtask

    task automatic t_mask;
        len_code = 2'd1; start_ref = 9'h1A5; sf_unblock_en = 1'b1;
        pulse(1, 0);
        send(9'h025, 0, 0);
        chk("R9 7b match wakes", {ev_start, wr_en, blocked}, 3'b110);
        send(9'h0A5, 0, 0);
        chk("R9 upper masked", {ev_start, wr_data}, {1'b1, 9'h025});
        len_code = 2'd3;
        send(9'h025, 0, 0);
        chk("R9 9b no match", ev_start, 0);
        sf_unblock_en = 1'b0; start_ref = 9'h1F0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_open_store();
        t_block_cmd();
        t_shut_drop();
        t_mp();
        t_start();
        t_sig();
        t_perr();
        t_mask();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule